// File: doc/BRIEF.md
# Address Translator with Associative Cache and Table Walk

This block turns a logical address into a physical address. The upper bits of the logical address form a page number and the lower bits form an in-page offset. A small fully associative translation cache compares every entry against the page number and the current address-space tag in the same cycle. When an entry matches, the frame number comes back one cycle after the request, and the memory port stays idle.

When no entry matches, the block first checks the page number against the configured table length. If the page number is inside the table, the block makes exactly one read from a flat page table in memory, at the table base plus the page number. A valid entry from that read gives the translation and is copied into the cache, into the slot that a rotating pointer selects. An entry marked invalid, or a page number outside the table, produces a fault with a cause code instead of an address.

Software sets the table base, the table length and the current address-space tag through a small write port. It can empty the whole cache, or only the entries that belong to one address-space tag.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd` and `rsp_fault` are 0. The table length resets to 0.
- R2: A successful translation returns `rsp_paddr` = {frame number, offset}. The low `OFF_W` bits equal the request's offset bits, and `rsp_fault`=0 with `rsp_cause`=0.
- R3: On a cache miss inside the table bounds, `mem_rd` pulses for exactly one cycle, the cycle after acceptance. It carries `mem_addr` = table base + page number.
- R4: A cache hit answers with `rsp_valid` one cycle after acceptance and makes no memory read.
- R5: A page number greater than or equal to the table length gives `rsp_fault`=1 with `rsp_cause`=2 one cycle after acceptance, and makes no memory read. A page number of length-1 is looked up normally.
- R6: A table entry is {valid at bit `PFN_W`, frame number in bits `PFN_W-1:0`}. An entry with valid=0 gives `rsp_fault`=1 with `rsp_cause`=1 and is not cached, so a repeat of the request reads memory again.
- R7: A cached entry hits only when both its page number and its address-space tag equal the request page number and the current tag.
- R8: Fills go to cache slots in round-robin order. With `TLB_N` entries, the fill after `TLB_N` distinct fills replaces the oldest one and leaves the others in place.
- R9: A pulse on `flush_all` invalidates every cached entry.
- R10: A pulse on `flush_tag_en` invalidates only the entries whose tag equals `flush_tag`.
- R11: While a table read is outstanding, `req_ready` is 0. The miss response arrives one cycle after `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write: 0 table base, 1 table length, 2 current tag |
| cfg_wdata | input | MA_W | Configuration write data |
| flush_all | input | 1 | Invalidate all cache entries |
| flush_tag_en | input | 1 | Invalidate the entries whose tag equals `flush_tag` |
| flush_tag | input | ASID_W | Tag selected for a selective flush |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | LA_W | Logical address: {page number, offset} |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address: {frame number, offset} |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 2 | 0 none, 1 invalid entry, 2 outside table |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | MA_W | Table entry address |
| mem_rvalid | input | 1 | Table read data present |
| mem_rdata | input | PTE_W | Table entry: {valid, frame number} |

## Verification
A stale or corrupt cache entry shows up on the very next request for that page. It either produces the wrong frame in `rsp_paddr`, or a hit with no read where a read was due, or the reverse. The bench therefore counts memory reads for each request and compares the count with what its own model of the cache predicts. A broken rotating pointer shows only after the cache wraps: the wrong page is evicted, and a later request reads memory when it should not, or skips a read it needs. Faults in the control state show within one or two cycles, as a missing `req_ready`, a second `mem_rd` pulse, or a response with the wrong latency.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int LA_W       = 16;
    localparam int PAGE_BYTES = 512;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int VPN_W      = LA_W - OFF_W;
    localparam int LEN_W      = VPN_W + 1;
    localparam int PFN_W      = 7;
    localparam int PA_W       = PFN_W + OFF_W;
    localparam int ASID_W     = 4;
    localparam int TLB_N      = 4;
    localparam int IDX_W      = $clog2(TLB_N);
    localparam int MA_W       = 16;
    localparam int PTE_W      = PFN_W + 1;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_BOUND   = 2'd2
    } fault_cause_e;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_LEN  = 2'd1,
        CFG_ASID = 2'd2
    } cfg_sel_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WAIT = 1'b1
    } walk_state_e;

    function automatic logic [PA_W-1:0] make_paddr(input logic [PFN_W-1:0] pfn,
                                                   input logic [OFF_W-1:0] off);
        return {pfn, off};
    endfunction
endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic              flush_all,
    input  logic              flush_tag_en,
    input  logic [ASID_W-1:0] flush_tag
);
    logic [TLB_N-1:0]            match;
    logic [TLB_N-1:0][PFN_W-1:0] pfn_sel;
    logic [IDX_W-1:0]            victim;

    for (genvar g = 0; g < TLB_N; g++) begin : g_ent
        tlb_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                if (ins_en && victim == IDX_W'(g)) begin
                    ent_q <= '{valid: 1'b1, asid: ins_asid, vpn: ins_vpn, pfn: ins_pfn};
                end
                if (flush_all || (flush_tag_en && ent_q.asid == flush_tag)) begin
                    ent_q.valid <= 1'b0;
                end
            end
        end

        assign match[g]   = ent_q.valid && ent_q.vpn == lk_vpn && ent_q.asid == lk_asid;
        assign pfn_sel[g] = match[g] ? ent_q.pfn : '0;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < TLB_N; i++) begin
            lk_pfn = lk_pfn | pfn_sel[i];
        end
    end

    assign lk_hit = |match;

    // rotating fill pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= '0;
        end else if (ins_en) begin
            victim <= (victim == IDX_W'(TLB_N - 1)) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_walker.sv
`timescale 1ns/1ps
module tlb_walker
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_fire,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              lk_hit,
    input  logic [PFN_W-1:0]  lk_pfn,
    input  logic              lk_oob,
    input  logic [MA_W-1:0]   pt_base,
    output logic              req_ready,
    output logic              mem_rd,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output fault_cause_e      rsp_cause,
    output logic              ins_en,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [PFN_W-1:0]  ins_pfn
);
    walk_state_e      state;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    pte_t             pte;

    assign pte       = pte_t'(mem_rdata);
    assign req_ready = (state == WS_IDLE);
    assign ins_en    = (state == WS_WAIT) && mem_rvalid && pte.valid;
    assign ins_vpn   = vpn_q;
    assign ins_pfn   = pte.pfn;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            vpn_q     <= '0;
            off_q     <= '0;
            mem_rd    <= 1'b0;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= 1'b0;
            mem_rd    <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_fire) begin
                        vpn_q <= req_vpn;
                        off_q <= req_off;
                        if (lk_oob) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_cause <= CAUSE_BOUND;
                            rsp_paddr <= '0;
                        end else if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_cause <= CAUSE_NONE;
                            rsp_paddr <= make_paddr(lk_pfn, req_off);
                        end else begin
                            state    <= WS_WAIT;
                            mem_rd   <= 1'b1;
                            mem_addr <= pt_base + MA_W'(req_vpn);
                        end
                    end
                end
                WS_WAIT: begin
                    if (mem_rvalid) begin
                        state     <= WS_IDLE;
                        rsp_valid <= 1'b1;
                        if (pte.valid) begin
                            rsp_fault <= 1'b0;
                            rsp_cause <= CAUSE_NONE;
                            rsp_paddr <= make_paddr(pte.pfn, off_q);
                        end else begin
                            rsp_fault <= 1'b1;
                            rsp_cause <= CAUSE_INVALID;
                            rsp_paddr <= '0;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [MA_W-1:0]   cfg_wdata,
    input  logic              flush_all,
    input  logic              flush_tag_en,
    input  logic [ASID_W-1:0] flush_tag,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_laddr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic              mem_rd,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata
);
    logic [MA_W-1:0]   pt_base;
    logic [LEN_W-1:0]  pt_len;
    logic [ASID_W-1:0] cur_asid;

    logic              req_fire;
    logic [VPN_W-1:0]  req_vpn;
    logic [OFF_W-1:0]  req_off;
    logic              lk_hit;
    logic              lk_oob;
    logic [PFN_W-1:0]  lk_pfn;
    logic              ins_en;
    logic [VPN_W-1:0]  ins_vpn;
    logic [PFN_W-1:0]  ins_pfn;
    fault_cause_e      cause_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_base  <= '0;
            pt_len   <= '0;
            cur_asid <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_BASE: pt_base  <= cfg_wdata;
                CFG_LEN:  pt_len   <= cfg_wdata[LEN_W-1:0];
                CFG_ASID: cur_asid <= cfg_wdata[ASID_W-1:0];
                default:  ;
            endcase
        end
    end

    assign req_fire  = req_valid && req_ready;
    assign req_vpn   = req_laddr[LA_W-1:OFF_W];
    assign req_off   = req_laddr[OFF_W-1:0];
    assign lk_oob    = {1'b0, req_vpn} >= pt_len;
    assign rsp_cause = cause_w;

    tlb_cam u_cam (
        .clk          (clk),
        .rst          (rst),
        .lk_vpn       (req_vpn),
        .lk_asid      (cur_asid),
        .lk_hit       (lk_hit),
        .lk_pfn       (lk_pfn),
        .ins_en       (ins_en),
        .ins_vpn      (ins_vpn),
        .ins_asid     (cur_asid),
        .ins_pfn      (ins_pfn),
        .flush_all    (flush_all),
        .flush_tag_en (flush_tag_en),
        .flush_tag    (flush_tag)
    );

    tlb_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .req_fire   (req_fire),
        .req_vpn    (req_vpn),
        .req_off    (req_off),
        .lk_hit     (lk_hit),
        .lk_pfn     (lk_pfn),
        .lk_oob     (lk_oob),
        .pt_base    (pt_base),
        .req_ready  (req_ready),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .rsp_cause  (cause_w),
        .ins_en     (ins_en),
        .ins_vpn    (ins_vpn),
        .ins_pfn    (ins_pfn)
    );
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_fire,
    input logic             lk_hit,
    input logic             lk_oob,
    input logic [VPN_W-1:0] req_vpn,
    input logic [MA_W-1:0]  pt_base,
    input logic             req_ready,
    input logic             mem_rd,
    input logic [MA_W-1:0]  mem_addr,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause
);
    p_miss_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        req_fire && !lk_oob && !lk_hit |=>
            mem_rd && mem_addr == $past(pt_base) + MA_W'($past(req_vpn)));

    p_single_read_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    p_hit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        req_fire && !lk_oob && lk_hit |=> rsp_valid && !rsp_fault && !mem_rd);

    p_bound_fault_r5: assert property (@(posedge clk) disable iff (rst)
        req_fire && lk_oob |=> rsp_valid && rsp_fault && rsp_cause == 2'd2 && !mem_rd);

    p_fault_coded_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    p_busy_walk_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !req_ready);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_fire  (req_fire),
    .lk_hit    (lk_hit),
    .lk_oob    (lk_oob),
    .req_vpn   (req_vpn),
    .pt_base   (pt_base),
    .req_ready (req_ready),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [1:0]        cfg_sel;
    logic [MA_W-1:0]   cfg_wdata;
    logic              flush_all;
    logic              flush_tag_en;
    logic [ASID_W-1:0] flush_tag;
    logic              req_valid;
    logic              req_ready;
    logic [LA_W-1:0]   req_laddr;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rsp_fault;
    logic [1:0]        rsp_cause;
    logic              mem_rd;
    logic [MA_W-1:0]   mem_addr;
    logic              mem_rvalid;
    logic [PTE_W-1:0]  mem_rdata;

    always #2 clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    localparam logic [MA_W-1:0] TB_BASE = 16'h0020;
    localparam int              TB_LEN  = 64;
    localparam int              BAD_VPN = 9;

    typedef struct {
        logic [PA_W-1:0] paddr;
        logic            fault;
        logic [1:0]      cause;
        string           tag;
    } exp_t;

    exp_t             sbq[$];
    logic [PTE_W-1:0] ptmem [256];
    int               rd_cnt;
    logic [MA_W-1:0]  last_addr;
    int               checks = 0;
    int               fails  = 0;

    function automatic logic [PFN_W-1:0] pfn_of(input int v);
        return PFN_W'((v * 5 + 3) % (1 << PFN_W));
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // memory model: one cycle read latency
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            rd_cnt     <= 0;
            last_addr  <= '0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_rd;
            if (mem_rd) begin
                rd_cnt    <= rd_cnt + 1;
                last_addr <= mem_addr;
                mem_rdata <= ptmem[mem_addr[7:0]];
            end
        end
    end

    // monitor: pop expected items as responses appear
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                e = sbq.pop_front();
                chk(rsp_fault == e.fault, e.tag, "fault flag", rsp_fault, e.fault);
                chk(rsp_cause == e.cause, e.tag, "cause code", rsp_cause, e.cause);
                if (!e.fault) chk(rsp_paddr == e.paddr, e.tag, "physical address", rsp_paddr, e.paddr);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [MA_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic do_flush_tag(input logic [ASID_W-1:0] t);
        @(negedge clk); flush_tag_en = 1'b1; flush_tag = t;
        @(negedge clk); flush_tag_en = 1'b0;
    endtask

    // driver: push expectation, issue request, check read count
    task automatic xlate(input int vpn, input int off, input bit fault,
                         input logic [1:0] cause, input int reads, input string tag);
        exp_t e;
        int   r0;
        e.paddr = {pfn_of(vpn), OFF_W'(off)};
        e.fault = fault;
        e.cause = cause;
        e.tag   = tag;
        sbq.push_back(e);
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = {VPN_W'(vpn), OFF_W'(off)};
        @(negedge clk);
        req_valid = 1'b0;
        if (reads > 0) chk(req_ready == 1'b0, "R11", "ready during walk", req_ready, 0);
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(rd_cnt - r0 == reads, tag, "table reads", rd_cnt - r0, reads);
        if (reads > 0) chk(last_addr == TB_BASE + MA_W'(vpn), "R3", "table address",
                           last_addr, TB_BASE + MA_W'(vpn));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            if (a >= int'(TB_BASE) && a < int'(TB_BASE) + 128)
                ptmem[a] = {(a - int'(TB_BASE)) != BAD_VPN, pfn_of(a - int'(TB_BASE))};
            else
                ptmem[a] = '0;
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        flush_all = 1'b0; flush_tag_en = 1'b0; flush_tag = '0;
        req_valid = 1'b0; req_laddr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(mem_rd == 1'b0, "R1", "mem_rd after reset", mem_rd, 0);
        // R1: length resets to 0, so everything is out of bounds
        xlate(0, 5, 1'b1, 2'd2, 0, "R1");

        cfg_write(2'd0, TB_BASE);
        cfg_write(2'd1, MA_W'(TB_LEN));
        cfg_write(2'd2, 16'd1);

        xlate(3, 'h1A5, 1'b0, 2'd0, 1, "R2");   // miss, fill
        xlate(3, 'h00F, 1'b0, 2'd0, 0, "R4");   // hit, other offset
        xlate(3, 'h1FF, 1'b0, 2'd0, 0, "R2");   // hit, top offset
        xlate(TB_LEN, 0, 1'b1, 2'd2, 0, "R5");  // first out of range
        xlate(127, 7, 1'b1, 2'd2, 0, "R5");
        xlate(TB_LEN - 1, 'h100, 1'b0, 2'd0, 1, "R5"); // last legal
        xlate(BAD_VPN, 1, 1'b1, 2'd1, 1, "R6");
        xlate(BAD_VPN, 1, 1'b1, 2'd1, 1, "R6");  // not cached

        cfg_write(2'd2, 16'd2);
        xlate(3, 'h022, 1'b0, 2'd0, 1, "R7");    // other tag misses
        cfg_write(2'd2, 16'd1);
        xlate(3, 'h023, 1'b0, 2'd0, 0, "R7");    // own tag hits

        do_flush_tag(4'd2);
        cfg_write(2'd2, 16'd2);
        xlate(3, 'h030, 1'b0, 2'd0, 1, "R10");   // tag 2 flushed
        cfg_write(2'd2, 16'd1);
        xlate(3, 'h031, 1'b0, 2'd0, 0, "R10");   // tag 1 kept

        do_flush_all();
        xlate(3, 'h040, 1'b0, 2'd0, 1, "R9");

        do_flush_all();
        for (int p = 10; p < 10 + TLB_N; p++) xlate(p, p, 1'b0, 2'd0, 1, "R8");
        xlate(10 + TLB_N, 1, 1'b0, 2'd0, 1, "R8"); // evicts page 10
        xlate(11, 2, 1'b0, 2'd0, 0, "R8");         // still cached
        xlate(10, 3, 1'b0, 2'd0, 1, "R8");         // was evicted

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule